// File: doc/BRIEF.md
# Real-Time Clock Interrupt and Status Controller

This block gathers the event sources of a bus-attached real-time clock and turns them into one active-low interrupt line. Each timekeeping counter delivers a one-cycle rollover pulse, and the time-compare logic delivers a one-cycle match pulse. The block latches every pulse into a sticky flag. It combines the flags with a write-only source mask and a master enable to drive the interrupt output.

A processor reaches the block over a small byte-wide register port. One address is shared by two registers: a read returns the status byte and a write loads the mask. That read also clears the flags, so each read reports only the events that occurred since the previous read. The top status bit is a global marker. It tells a processor polling several devices whether this block is the one that pulled the interrupt line. The next address holds a write-only command byte. That byte carries the interrupt enable and a test-mode select, which is passed on to the counter chain so that the chain can count on the bus clock instead of the slow periodic tick.

Top module: `rtc_irq_ctrl`

## Requirements
- R1: While reset is active and after it is released, flags, mask, enable, test select and global marker are all 0, so irq_n_o is 1, test_mode_o is 0 and a status read returns 8'h00.
- R2: A pulse on src_evt_i[i] sets flag i on the next clock edge. The source bits are: bit 0 alarm match, bit 1 hundredths, bit 2 seconds, bit 3 minutes, bit 4 hours, bit 5 days. A read at address 5'h10 returns flag i in data bit i, with bit 6 always 0.
- R3: A read at 5'h10 returns the flags as they stood before the read edge and clears them at that edge. A source pulse in the same cycle as the read is not in the returned byte and is set for the next read.
- R4: A write at 5'h10 loads the mask from wdata[5:0], with mask bit i gating source i. The mask is write-only: a read at 5'h10 never returns it.
- R5: A write at 5'h11 loads the interrupt enable from wdata[4] and the test select from wdata[5]. Both are write-only.
- R6: irq_n_o is 0 exactly when the enable is 1 and at least one flag has its mask bit set. It goes low in the cycle after the edge that captured the pulse, and it returns to 1 after the status read that clears those flags.
- R7: Status bit 7 reads 1 when irq_n_o is low, or when it was low at any point since the last status read. The bit stays 1 after the mask or enable drops, and the status read clears it.
- R8: test_mode_o equals the last test select written (1 = counters advance on the bus clock, 0 = normal tick).
- R9: Reads at any address other than 5'h10 return 8'h00 and clear nothing. Writes at any address other than 5'h10 and 5'h11 change no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus and logic clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| src_evt_i | input | 6 | One-cycle event pulses: alarm, hundredths, seconds, minutes, hours, days |
| bus_addr_i | input | 5 | Register address |
| bus_rd_i | input | 1 | Read strobe, one cycle per access |
| bus_wr_i | input | 1 | Write strobe, one cycle per access |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, valid while bus_rd_i is high |
| irq_n_o | output | 1 | Active-low interrupt request |
| test_mode_o | output | 1 | Selects bus-clock stepping of the counter chain |

## Verification
The bench steps through every mask value for each single source, with the enable both off and on. For each case it checks that the interrupt line and the global bit follow mask and enable exactly. A swapped mask bit or a global bit that ignores the enable would show up as a wrong line level or a wrong status byte. A source pulse placed in the same cycle as a status read is checked separately: a design that cleared after the merge would lose that event, and one that merged before the return would report it too early. The bench also checks that the global bit stays set after the mask is dropped, and that reads and writes at foreign addresses change nothing. A design without sticky global state, or with loose address decode, fails those checks.

// File: rtl/rtc_irq_pkg.sv
package rtc_irq_pkg;
  localparam int unsigned ADDR_W     = 5;
  localparam int unsigned DATA_W     = 8;
  localparam logic [ADDR_W-1:0] STAT_MASK_ADDR = 5'h10;
  localparam logic [ADDR_W-1:0] CMD_ADDR       = 5'h11;
  localparam int unsigned EN_BIT     = 4;
  localparam int unsigned TEST_BIT   = 5;
  localparam int unsigned GLOBAL_BIT = 7;
endpackage

// File: rtl/rtc_irq_rst_sync.sv
module rtc_irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic stage_q;
  logic sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      stage_q <= 1'b0;
      sync_q  <= 1'b0;
    end else begin
      stage_q <= 1'b1;
      sync_q  <= stage_q;
    end
  end

  assign rst_n_sync = sync_q;
endmodule

// File: rtl/rtc_irq_regs.sv
module rtc_irq_regs
  import rtc_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr,
  input  logic [DATA_W-1:0] wdata,
  output logic [NUM_SRC-1:0] mask,
  output logic              irq_en,
  output logic              test_sel
);
  logic               mask_we;
  logic               cmd_we;
  logic [NUM_SRC-1:0] mask_d;
  logic               en_d;
  logic               test_d;
  logic               unused_wdata_bits;

  assign unused_wdata_bits = ^wdata;

  always_comb begin
    mask_we = wr && (addr == STAT_MASK_ADDR);
    cmd_we  = wr && (addr == CMD_ADDR);
    mask_d  = mask;
    en_d    = irq_en;
    test_d  = test_sel;
    if (mask_we) mask_d = wdata[NUM_SRC-1:0];
    if (cmd_we) begin
      en_d   = wdata[EN_BIT];
      test_d = wdata[TEST_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask     <= '0;
      irq_en   <= 1'b0;
      test_sel <= 1'b0;
    end else begin
      mask     <= mask_d;
      irq_en   <= en_d;
      test_sel <= test_d;
    end
  end

  // R4
  mask_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && addr == STAT_MASK_ADDR) |=> (mask == $past(wdata[NUM_SRC-1:0])));

  // R9
  foreign_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(wr && (addr == STAT_MASK_ADDR || addr == CMD_ADDR)))
      |=> ($stable(mask) && $stable(irq_en) && $stable(test_sel)));
endmodule

// File: rtl/rtc_irq_flags.sv
module rtc_irq_flags #(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] evt,
  input  logic               clr,
  output logic [NUM_SRC-1:0] flags
);
  logic [NUM_SRC-1:0] flags_d;

  for (genvar i = 0; i < NUM_SRC; i++) begin : g_flag
    always_comb begin
      flags_d[i] = clr ? evt[i] : (flags[i] | evt[i]);
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) flags[i] <= 1'b0;
      else        flags[i] <= flags_d[i];
    end
  end

  // R2
  evt_capture_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|evt) |=> ((flags & $past(evt)) == $past(evt)));

  // R3
  read_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr && evt == '0) |=> (flags == '0));
endmodule

// File: rtl/rtc_irq_out.sv
module rtc_irq_out #(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] flags,
  input  logic [NUM_SRC-1:0] mask,
  input  logic               irq_en,
  input  logic               clr,
  output logic               irq_n,
  output logic               global_bit
);
  logic irq_act;
  logic global_q;
  logic global_d;

  always_comb begin
    irq_act    = irq_en && (|(flags & mask));
    global_d   = clr ? 1'b0 : (global_q | irq_act);
    irq_n      = ~irq_act;
    global_bit = global_q | irq_act;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) global_q <= 1'b0;
    else        global_q <= global_d;
  end

  // R6
  irq_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_en) |-> irq_n);

  // R7
  global_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!irq_n && !clr) |=> global_q);
endmodule

// File: rtl/rtc_irq_ctrl.sv
module rtc_irq_ctrl
  import rtc_irq_pkg::*;
#(
  parameter int unsigned NUM_SRC = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_evt_i,
  input  logic [ADDR_W-1:0]  bus_addr_i,
  input  logic               bus_rd_i,
  input  logic               bus_wr_i,
  input  logic [DATA_W-1:0]  bus_wdata_i,
  output logic [DATA_W-1:0]  bus_rdata_o,
  output logic               irq_n_o,
  output logic               test_mode_o
);
  logic               rst_n_s;
  logic               stat_rd;
  logic [NUM_SRC-1:0] flags;
  logic [NUM_SRC-1:0] mask;
  logic               irq_en;
  logic               global_bit;

  rtc_irq_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_n_sync (rst_n_s)
  );

  assign stat_rd = bus_rd_i && (bus_addr_i == STAT_MASK_ADDR);

  rtc_irq_regs #(.NUM_SRC(NUM_SRC)) u_regs (
    .clk      (clk),
    .rst_n    (rst_n_s),
    .addr     (bus_addr_i),
    .wr       (bus_wr_i),
    .wdata    (bus_wdata_i),
    .mask     (mask),
    .irq_en   (irq_en),
    .test_sel (test_mode_o)
  );

  rtc_irq_flags #(.NUM_SRC(NUM_SRC)) u_flags (
    .clk   (clk),
    .rst_n (rst_n_s),
    .evt   (src_evt_i),
    .clr   (stat_rd),
    .flags (flags)
  );

  rtc_irq_out #(.NUM_SRC(NUM_SRC)) u_out (
    .clk        (clk),
    .rst_n      (rst_n_s),
    .flags      (flags),
    .mask       (mask),
    .irq_en     (irq_en),
    .clr        (stat_rd),
    .irq_n      (irq_n_o),
    .global_bit (global_bit)
  );

  always_comb begin
    bus_rdata_o = '0;
    if (stat_rd) begin
      bus_rdata_o[NUM_SRC-1:0] = flags;
      bus_rdata_o[GLOBAL_BIT]  = global_bit;
    end
  end

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    (!rst_n_s) |-> (irq_n_o && !test_mode_o));
endmodule

// File: tb/rtc_irq_ctrl_tb_top.sv
`timescale 1ns/1ps
module rtc_irq_ctrl_tb_top;
  logic       clk = 1'b0;
  logic       rst_n;
  logic [5:0] src_evt;
  logic [4:0] addr;
  logic       rd, wr;
  logic [7:0] wdata, rdata;
  logic       irq_n, test_mode;

  int total = 0;
  int bad   = 0;
  bit done  = 0;

  always #2.5 clk = ~clk;

  rtc_irq_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .src_evt_i(src_evt), .bus_addr_i(addr),
    .bus_rd_i(rd), .bus_wr_i(wr), .bus_wdata_i(wdata), .bus_rdata_o(rdata),
    .irq_n_o(irq_n), .test_mode_o(test_mode)
  );

  task automatic check(input string req, input string what,
                       input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic bus_write(input logic [4:0] a, input logic [7:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [4:0] a, output logic [7:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic pulse(input logic [5:0] v);
    @(negedge clk); src_evt = v;
    @(negedge clk); src_evt = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [7:0] d;
    rst_n = 1'b0; src_evt = '0; addr = '0; rd = 1'b0; wr = 1'b0; wdata = '0;
    repeat (4) @(negedge clk);
    check("R1", "irq during reset", {7'd0, irq_n}, 8'h01);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);

    // R1 reset state
    check("R1", "irq after reset", {7'd0, irq_n}, 8'h01);
    check("R1", "test after reset", {7'd0, test_mode}, 8'h00);
    bus_read(5'h10, d);
    check("R1", "status after reset", d, 8'h00);

    // R4 mask is write-only
    bus_write(5'h10, 8'h2A);
    bus_read(5'h10, d);
    check("R4", "mask not readable", d, 8'h00);

    // R2 R6 R7 R3 sweep: every mask, every source, enable off and on
    for (int en = 0; en < 2; en++) begin
      for (int m = 0; m < 64; m++) begin
        for (int s = 0; s < 6; s++) begin
          logic hit;
          logic [7:0] exp;
          hit = (en == 1) && m[s];
          exp = (hit ? 8'h80 : 8'h00) | (8'h01 << s);
          bus_write(5'h10, m[7:0]);
          bus_write(5'h11, en[0] ? 8'h10 : 8'h00);
          pulse(6'b1 << s);
          #1;
          check("R6", "irq level", {7'd0, irq_n}, {7'd0, ~hit});
          bus_read(5'h10, d);
          check("R2", "status byte", d, exp);
          #1;
          check("R3", "irq after clearing read", {7'd0, irq_n}, 8'h01);
        end
      end
    end

    // R3 event in same cycle as read is kept
    bus_write(5'h10, 8'h3F);
    bus_write(5'h11, 8'h10);
    pulse(6'h04);
    @(negedge clk); addr = 5'h10; rd = 1'b1; src_evt = 6'h08;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0; src_evt = '0;
    check("R3", "read during event", d, 8'h84);
    #1;
    check("R3", "irq held by late event", {7'd0, irq_n}, 8'h00);
    bus_read(5'h10, d);
    check("R3", "late event kept", d, 8'h88);
    bus_read(5'h10, d);
    check("R3", "cleared after second read", d, 8'h00);

    // R7 global stays after mask drops
    pulse(6'h01);
    bus_write(5'h10, 8'h00);
    #1;
    check("R7", "irq released by mask", {7'd0, irq_n}, 8'h01);
    bus_read(5'h10, d);
    check("R7", "global sticky", d, 8'h81);
    bus_read(5'h10, d);
    check("R7", "global cleared", d, 8'h00);

    // R9 foreign addresses
    bus_write(5'h10, 8'h3F);
    bus_write(5'h11, 8'h10);
    bus_write(5'h12, 8'h00);
    bus_write(5'h03, 8'h00);
    pulse(6'h02);
    #1;
    check("R9", "irq after foreign writes", {7'd0, irq_n}, 8'h00);
    bus_read(5'h11, d);
    check("R9", "read cmd addr", d, 8'h00);
    bus_read(5'h05, d);
    check("R9", "read other addr", d, 8'h00);
    #1;
    check("R9", "foreign read no clear", {7'd0, irq_n}, 8'h00);
    bus_read(5'h10, d);
    check("R9", "flags intact", d, 8'h82);

    // R5 R8 command bits
    bus_write(5'h11, 8'h20);
    #1;
    check("R8", "test select on", {7'd0, test_mode}, 8'h01);
    pulse(6'h10);
    #1;
    check("R5", "enable off with test on", {7'd0, irq_n}, 8'h01);
    bus_write(5'h11, 8'h30);
    #1;
    check("R5", "enable on", {7'd0, irq_n}, 8'h00);
    bus_write(5'h11, 8'h10);
    #1;
    check("R8", "test select off", {7'd0, test_mode}, 8'h00);
    bus_read(5'h10, d);
    check("R5", "status after enable", d, 8'h90);

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule